// File: doc/BRIEF.md
# Next-Block Pointer Branch Target Table

This block steers instruction fetch one fetch block at a time. It keeps a small table, separate from the instruction cache, that holds one short pointer per fetch block: the index of the block expected to follow it. Each cycle the current guess block index reads its own entry. The pointer that comes out, unless something overrides it, becomes the block index sent to the instruction cache in the next cycle. The lookup path is one table read, one three-way select and one register.

Two sources can override the table's guess. A restart from the back end, sent after a resolved misprediction, always wins. A correction from the branch direction predictor wins over the table pointer but loses to a restart. Learning uses a separate update port that is not on the lookup path. Each entry carries a 2-bit confidence counter. A matching update raises it, and a differing update lowers it. The stored pointer is replaced only when a differing update finds the counter already at zero.

Top module: `nextBlockBtb`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fetchBlock` is 0. Reset loads every entry i with pointer (i+1) modulo the table depth and confidence 0.
- R2: With no override, the next `fetchBlock` is the stored pointer of the entry indexed by the current `fetchBlock`.
- R3: When `restartValid` is 1, `fetchBlock` equals `restartBlock` after the next clock edge.
- R4: When `fixValid` is 1 and `restartValid` is 0, `fetchBlock` equals `fixBlock` after the next clock edge.
- R5: When both overrides are valid in one cycle, the restart is taken and the correction is dropped.
- R6: An update whose `updNext` differs from the stored pointer while the entry's confidence is 0 replaces the pointer with `updNext`, and the confidence stays 0.
- R7: An update whose `updNext` equals the stored pointer raises the confidence by one, saturating at 3, and keeps the pointer.
- R8: An update whose `updNext` differs from the stored pointer while the confidence is above 0 lowers the confidence by one and keeps the pointer.
- R9: When an update writes the entry being read in the same cycle, the read returns the contents from before the update. The new contents are seen from the next cycle on.
- R10: With `updValid` at 0, the values on `updBlock` and `updNext` do not change the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restartValid | input | 1 | Back-end restart request |
| restartBlock | input | IDX_W | Block index to restart at |
| fixValid | input | 1 | Direction-predictor correction request |
| fixBlock | input | IDX_W | Corrected next block index |
| updValid | input | 1 | Table update strobe |
| updBlock | input | IDX_W | Entry being trained |
| updNext | input | IDX_W | Observed successor block of that entry |
| fetchBlock | output | IDX_W | Current fetch block index to the instruction cache |

## Verification
The bench builds the block with IDX_W = 4, which gives a 16-entry table. With this size a short free run reaches the wrap of the last entry back to block 0, and every reset pointer can be checked with a few restarts. The small index also keeps the stimulus table short enough to combine restarts, corrections and free-running walks in one pass. Confidence training is driven past saturation and back down to zero, so that a counter which wraps instead of saturating changes which pointer a later probe reads.

// File: rtl/nextBlockBtb_pkg.sv
package nextBlockBtb_pkg;

  localparam int CONF_W = 2;
  localparam logic [CONF_W-1:0] CONF_MAX = '1;

  typedef enum logic [1:0] {
    SRC_TABLE   = 2'd0,
    SRC_FIX     = 2'd1,
    SRC_RESTART = 2'd2
  } nextSrcT;

  typedef struct packed {
    nextSrcT           src;
    logic              wrEn;
    logic              wrPtr;
    logic [CONF_W-1:0] confNext;
  } btbStrobeT;

endpackage

// File: rtl/nextBlockBtbCtrl.sv
module nextBlockBtbCtrl
  import nextBlockBtb_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic              restartValid,
  input  logic              fixValid,
  input  logic              updValid,
  input  logic [IDX_W-1:0]  updNext,
  input  logic [IDX_W-1:0]  storedPtr,
  input  logic [CONF_W-1:0] storedConf,
  output btbStrobeT         strobes
);

  logic updHit;
  logic confAtMax;
  logic confAtZero;

  assign updHit     = (storedPtr == updNext);
  assign confAtMax  = (storedConf == CONF_MAX);
  assign confAtZero = (storedConf == '0);

  // Override priority: restart, then correction, then table pointer.
  always_comb begin
    if (restartValid)  strobes.src = SRC_RESTART;
    else if (fixValid) strobes.src = SRC_FIX;
    else               strobes.src = SRC_TABLE;
  end

  // Hysteresis training, off the lookup path.
  always_comb begin
    strobes.wrEn     = updValid;
    strobes.wrPtr    = 1'b0;
    strobes.confNext = storedConf;
    if (updValid) begin
      if (updHit) begin
        strobes.confNext = confAtMax ? storedConf : storedConf + 1'b1;
      end else if (confAtZero) begin
        strobes.wrPtr    = 1'b1;
        strobes.confNext = '0;
      end else begin
        strobes.confNext = storedConf - 1'b1;
      end
    end
  end

endmodule

// File: rtl/nextBlockBtbData.sv
module nextBlockBtbData
  import nextBlockBtb_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  btbStrobeT         strobes,
  input  logic              restartValid,
  input  logic              fixValid,
  input  logic              updValid,
  input  logic [IDX_W-1:0]  restartBlock,
  input  logic [IDX_W-1:0]  fixBlock,
  input  logic [IDX_W-1:0]  updBlock,
  input  logic [IDX_W-1:0]  updNext,
  output logic [IDX_W-1:0]  storedPtr,
  output logic [CONF_W-1:0] storedConf,
  output logic [IDX_W-1:0]  fetchBlock
);

  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0]  ptrMem  [DEPTH];
  logic [CONF_W-1:0] confMem [DEPTH];
  logic [IDX_W-1:0]  tableRead;
  logic [IDX_W-1:0]  nextBlock;

  assign tableRead  = ptrMem[fetchBlock];
  assign storedPtr  = ptrMem[updBlock];
  assign storedConf = confMem[updBlock];

  always_comb begin
    unique case (strobes.src)
      SRC_RESTART: nextBlock = restartBlock;
      SRC_FIX:     nextBlock = fixBlock;
      default:     nextBlock = tableRead;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetchBlock <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ptrMem[i]  <= IDX_W'(i + 1);
        confMem[i] <= '0;
      end
    end else begin
      fetchBlock <= nextBlock;
      if (strobes.wrEn) begin
        confMem[updBlock] <= strobes.confNext;
        if (strobes.wrPtr) ptrMem[updBlock] <= updNext;
      end
    end
  end

  AST_RESTART_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    restartValid |=> fetchBlock == $past(restartBlock)); // R3
  AST_FIX_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fixValid && !restartValid) |=> fetchBlock == $past(fixBlock)); // R4
  AST_RESTART_OVER_FIX: assert property (@(posedge clk) disable iff (!rst_n)
    (fixValid && restartValid && fixBlock != restartBlock) |=> fetchBlock != $past(fixBlock)); // R5
  AST_REPLACE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (updValid && confMem[updBlock] == '0 && ptrMem[updBlock] != updNext)
      |=> ptrMem[$past(updBlock)] == $past(updNext)); // R6
  AST_HIT_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (updValid && ptrMem[updBlock] == updNext)
      |=> ptrMem[$past(updBlock)] == $past(updNext)); // R7
  AST_HIT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (updValid && ptrMem[updBlock] == updNext)
      |=> confMem[$past(updBlock)] != '0); // R7
  AST_MISS_DECAY: assert property (@(posedge clk) disable iff (!rst_n)
    (updValid && confMem[updBlock] != '0 && ptrMem[updBlock] != updNext)
      |=> ptrMem[$past(updBlock)] == $past(ptrMem[updBlock])); // R8
  AST_READ_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (updValid && updBlock == fetchBlock && !restartValid && !fixValid)
      |=> fetchBlock == $past(ptrMem[fetchBlock])); // R9

endmodule

// File: rtl/nextBlockBtb.sv
module nextBlockBtb
  import nextBlockBtb_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restartValid,
  input  logic [IDX_W-1:0] restartBlock,
  input  logic             fixValid,
  input  logic [IDX_W-1:0] fixBlock,
  input  logic             updValid,
  input  logic [IDX_W-1:0] updBlock,
  input  logic [IDX_W-1:0] updNext,
  output logic [IDX_W-1:0] fetchBlock
);

  btbStrobeT         strobes;
  logic [IDX_W-1:0]  storedPtr;
  logic [CONF_W-1:0] storedConf;

  nextBlockBtbCtrl #(.IDX_W(IDX_W)) ctrl_i (
    .restartValid (restartValid),
    .fixValid     (fixValid),
    .updValid     (updValid),
    .updNext      (updNext),
    .storedPtr    (storedPtr),
    .storedConf   (storedConf),
    .strobes      (strobes)
  );

  nextBlockBtbData #(.IDX_W(IDX_W)) data_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobes      (strobes),
    .restartValid (restartValid),
    .fixValid     (fixValid),
    .updValid     (updValid),
    .restartBlock (restartBlock),
    .fixBlock     (fixBlock),
    .updBlock     (updBlock),
    .updNext      (updNext),
    .storedPtr    (storedPtr),
    .storedConf   (storedConf),
    .fetchBlock   (fetchBlock)
  );

  AST_UPDATE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !updValid |-> !strobes.wrEn); // R10

endmodule

// File: tb/nextBlockBtb_tb.sv
module nextBlockBtb_tb_top;

  localparam int IDX_W = 4;
  localparam time CLK_P = 20ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restartValid = 1'b0;
  logic [IDX_W-1:0] restartBlock = '0;
  logic fixValid = 1'b0;
  logic [IDX_W-1:0] fixBlock = '0;
  logic updValid = 1'b0;
  logic [IDX_W-1:0] updBlock = '0;
  logic [IDX_W-1:0] updNext = '0;
  logic [IDX_W-1:0] fetchBlock;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  nextBlockBtb #(.IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .restartValid(restartValid), .restartBlock(restartBlock),
    .fixValid(fixValid), .fixBlock(fixBlock),
    .updValid(updValid), .updBlock(updBlock), .updNext(updNext),
    .fetchBlock(fetchBlock)
  );

  // {restartValid, restartBlock, fixValid, fixBlock, expected fetchBlock}
  localparam int NVEC = 10;
  localparam logic [13:0] VEC [NVEC] = '{
    {1'b0, 4'd0,  1'b0, 4'd0,  4'd1},   // R2
    {1'b0, 4'd0,  1'b0, 4'd0,  4'd2},   // R2
    {1'b1, 4'd14, 1'b0, 4'd0,  4'd14},  // R3
    {1'b0, 4'd0,  1'b0, 4'd0,  4'd15},  // R2
    {1'b0, 4'd0,  1'b0, 4'd0,  4'd0},   // R1 wrap
    {1'b0, 4'd0,  1'b1, 4'd9,  4'd9},   // R4
    {1'b0, 4'd0,  1'b0, 4'd0,  4'd10},  // R2
    {1'b1, 4'd3,  1'b1, 4'd12, 4'd3},   // R5
    {1'b0, 4'd0,  1'b1, 4'd6,  4'd6},   // R4
    {1'b0, 4'd0,  1'b0, 4'd0,  4'd7}    // R2
  };

  task automatic check(input string req, input logic [IDX_W-1:0] act, input logic [IDX_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: fetchBlock=%0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doUpdate(input logic [IDX_W-1:0] idx, input logic [IDX_W-1:0] nxt);
    updValid = 1'b1; updBlock = idx; updNext = nxt;
    @(negedge clk);
    updValid = 1'b0;
  endtask

  task automatic probe(input string req, input logic [IDX_W-1:0] idx, input logic [IDX_W-1:0] exp);
    restartValid = 1'b1; restartBlock = idx;
    @(negedge clk);
    restartValid = 1'b0;
    @(negedge clk);
    check(req, fetchBlock, exp);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", fetchBlock, 4'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      restartValid = VEC[v][13];
      restartBlock = VEC[v][12:9];
      fixValid     = VEC[v][8];
      fixBlock     = VEC[v][7:4];
      @(negedge clk);
      check($sformatf("R2-R5 vector %0d", v), fetchBlock, VEC[v][3:0]);
    end
    restartValid = 1'b0; fixValid = 1'b0;

    probe("R1 reset pointer", 4'd5, 4'd6);

    doUpdate(4'd5, 4'd9);
    probe("R6 replace", 4'd5, 4'd9);

    repeat (4) doUpdate(4'd5, 4'd9);
    repeat (3) doUpdate(4'd5, 4'd2);
    probe("R8 decay keeps pointer, R7 saturation", 4'd5, 4'd9);

    doUpdate(4'd5, 4'd2);
    probe("R6 replace after decay", 4'd5, 4'd2);

    updValid = 1'b0; updBlock = 4'd5; updNext = 4'd11;
    @(negedge clk);
    probe("R10 gated update", 4'd5, 4'd2);

    restartValid = 1'b1; restartBlock = 4'd7;
    @(negedge clk);
    restartValid = 1'b0;
    check("R3 restart", fetchBlock, 4'd7);
    updValid = 1'b1; updBlock = 4'd7; updNext = 4'd12;
    @(negedge clk);
    updValid = 1'b0;
    check("R9 read old", fetchBlock, 4'd8);
    probe("R9 new contents", 4'd7, 4'd12);

    rst_n = 1'b0;
    #1;
    check("R1 async reset", fetchBlock, 4'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 first step", fetchBlock, 4'd1);
    probe("R1 table reinit", 4'd5, 4'd6);
    probe("R1 last entry wraps", 4'd15, 4'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule